// File: doc/BRIEF.md
# Comparator Timer Channel

One channel of an event timer. The channel holds a comparator and compares it with a shared free-running main counter. When the comparator is reached, the channel raises an interrupt: either a one-cycle edge pulse or a sticky status bit that stays up until software clears it. The channel can run in one-shot or periodic mode. In periodic mode the comparator steps forward by a stored period after each match. Comparison is 64 bits wide, or 32 bits wide when the narrow mode is selected.

The channel checks the comparator against the counter whenever it is armed. Arming happens on a comparator write, on a config write, or when the global enable rises. A comparator that is already behind the counter at arming time fires at once in 64-bit mode. In 32-bit mode it fires at once only if it is no more than `PAST_WIN` ticks behind. A larger gap is taken as a target beyond the next 32-bit wrap. The main counter is expected to advance by at most one per clock. Channel index 0 also quiets the legacy interval timer while global legacy routing is on.

Top module: `chan_timer`

## Requirements
- R1: After reset the status bit, the edge pulse, the comparator readback and the route output are 0. The config readback reads 64'h00F0_0000_0000_0030.
- R2: These config bits are writable: bit 1 (level type), bit 2 (interrupt enable), bit 3 (periodic), bit 8 (force 32-bit) and bits 13:9 (route number, mirrored on `irq_route`). Bits 4 and 5 read as 1, meaning periodic-capable and 64-bit-capable. Bits 63:32 read as the route-capability mask 32'h00F0_0000. All other bits read 0 and ignore writes.
- R3: While the channel is armed, globally enabled and interrupt-enabled, a clock edge that samples the counter equal to the comparator fires the channel. The effect is visible on the outputs right after that edge.
- R4: In 32-bit mode, only the low 32 bits of the comparator and of the counter take part in every comparison.
- R5: An arming event takes effect one clock later. At that edge, in 64-bit mode, a comparator behind the counter (negative signed difference comparator minus counter) or equal to it fires at once.
- R6: In 32-bit mode, a comparator 1 to `PAST_WIN` ticks behind the counter (32-bit signed difference) fires at once at the arming evaluation. A comparator further behind does not fire until the counter reaches it after the wrap.
- R7: Periodic mode: each fire adds the period to the comparator. The period is the value of the last comparator write. One-shot mode: after a fire the channel does not fire again until it is re-armed, even while the counter still equals the comparator.
- R8: A comparator write in the same cycle as a periodic reload wins. The comparator takes the written value.
- R9: Level type: a fire sets `irq_sts`. The bit stays set until `sts_clr` is high at a clock edge. A fire and a clear at the same edge leave the bit set.
- R10: Edge type: a fire gives a one-cycle `irq_pulse`, and `irq_sts` is left unchanged.
- R11: While `glb_en` is low the channel never fires and drops its armed state. A rising `glb_en` re-evaluates the comparator against the counter.
- R12: `legacy_quiet` follows `glb_legacy` on channel index 0 and is 0 on every other channel.
- R13: With interrupt enable clear, the channel does not fire, even for a comparator that is behind the counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| main_cnt | input | 64 | Shared main counter value |
| glb_en | input | 1 | Global counter and interrupt enable |
| glb_legacy | input | 1 | Global legacy routing active |
| cfg_we | input | 1 | Config register write strobe |
| cfg_wdata | input | 64 | Config write data |
| cmp_we | input | 1 | Comparator write strobe (also loads period) |
| cmp_wdata | input | 64 | Comparator write data |
| sts_clr | input | 1 | Write-1 clear of the status bit |
| cfg_rd | output | 64 | Config readback including capability fields |
| cmp_rd | output | 64 | Current comparator value |
| irq_route | output | 5 | Selected interrupt route number |
| irq_sts | output | 1 | Level-type status / interrupt line |
| irq_pulse | output | 1 | One-cycle edge-type interrupt |
| legacy_quiet | output | 1 | Suppress request to the legacy interval timer |

## Verification
Two pairs of events can meet in one cycle. The first is a periodic reload and a software comparator write at the same edge. The bench provokes it by writing a new comparator on the very edge where the counter reaches the old one. It then expects both the edge pulse and the written value, not the reloaded one, in the comparator. The second is a level fire and a status clear at the same edge. The bench holds `sts_clr` high across the match cycle and expects the status bit to survive that edge and to fall on the next one. Past-value handling is exercised from a table of comparator/counter pairs around the window boundary, the 32-bit truncation and the wrap.

// File: rtl/chan_tmr_pkg.sv
package chan_tmr_pkg;
  localparam int CFG_W       = 64;
  localparam int ROUTE_W     = 5;
  localparam int CB_LEVEL    = 1;
  localparam int CB_INTEN    = 2;
  localparam int CB_PERIODIC = 3;
  localparam int CB_PER_CAP  = 4;
  localparam int CB_WIDE_CAP = 5;
  localparam int CB_NARROW   = 8;
  localparam int CB_ROUTE_LO = 9;
  localparam int CB_ROUTE_HI = CB_ROUTE_LO + ROUTE_W - 1;
  localparam int CB_CAP_LO   = 32;

  typedef struct packed {
    logic               level;
    logic               int_en;
    logic               periodic;
    logic               narrow;
    logic [ROUTE_W-1:0] route;
  } chan_cfg_t;
endpackage

// File: rtl/chan_cfg_reg.sv
module chan_cfg_reg
  import chan_tmr_pkg::*;
#(
  parameter logic [31:0] ROUTE_CAP = 32'h00F0_0000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [CFG_W-1:0] wdata,
  output chan_cfg_t        cfg,
  output logic [CFG_W-1:0] rd_val
);
  chan_cfg_t cfg_q, cfg_nxt;

  logic unused_wbits;
  assign unused_wbits = ^{wdata[CFG_W-1:CB_ROUTE_HI+1], wdata[CB_NARROW-1:CB_PER_CAP], wdata[0]};

  always_comb begin
    cfg_nxt = cfg_q;
    if (we) begin
      cfg_nxt.level    = wdata[CB_LEVEL];
      cfg_nxt.int_en   = wdata[CB_INTEN];
      cfg_nxt.periodic = wdata[CB_PERIODIC];
      cfg_nxt.narrow   = wdata[CB_NARROW];
      cfg_nxt.route    = wdata[CB_ROUTE_HI:CB_ROUTE_LO];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_q <= '0;
    else        cfg_q <= cfg_nxt;
  end

  always_comb begin
    rd_val                          = '0;
    rd_val[CFG_W-1:CB_CAP_LO]       = ROUTE_CAP;
    rd_val[CB_PER_CAP]              = 1'b1;
    rd_val[CB_WIDE_CAP]             = 1'b1;
    rd_val[CB_LEVEL]                = cfg_q.level;
    rd_val[CB_INTEN]                = cfg_q.int_en;
    rd_val[CB_PERIODIC]             = cfg_q.periodic;
    rd_val[CB_NARROW]               = cfg_q.narrow;
    rd_val[CB_ROUTE_HI:CB_ROUTE_LO] = cfg_q.route;
  end

  assign cfg = cfg_q;
endmodule

// File: rtl/chan_match.sv
module chan_match #(
  parameter int CNT_W    = 64,
  parameter int NARROW_W = 32,
  parameter int PAST_WIN = 14318
) (
  input  logic [CNT_W-1:0] cnt,
  input  logic [CNT_W-1:0] cmp,
  input  logic             narrow,
  output logic             hit,
  output logic             behind_fire
);
  localparam logic [NARROW_W-1:0] WIN_N = NARROW_W'(PAST_WIN);

  logic [CNT_W-1:0]    diff_w;
  logic [NARROW_W-1:0] diff_n;
  logic [NARROW_W-1:0] lag_n;

  always_comb begin
    diff_w = cmp - cnt;
    diff_n = cmp[NARROW_W-1:0] - cnt[NARROW_W-1:0];
    lag_n  = -diff_n;
    if (narrow) begin
      hit         = (diff_n == '0);
      behind_fire = diff_n[NARROW_W-1] && (lag_n <= WIN_N);
    end else begin
      hit         = (diff_w == '0);
      behind_fire = diff_w[CNT_W-1];
    end
  end
endmodule

// File: rtl/chan_timer.sv
module chan_timer
  import chan_tmr_pkg::*;
#(
  parameter int          CNT_W     = 64,
  parameter int          NARROW_W  = 32,
  parameter int          CHAN_ID   = 0,
  parameter int          PAST_WIN  = 14318,
  parameter logic [31:0] ROUTE_CAP = 32'h00F0_0000
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [CNT_W-1:0]   main_cnt,
  input  logic               glb_en,
  input  logic               glb_legacy,
  input  logic               cfg_we,
  input  logic [CFG_W-1:0]   cfg_wdata,
  input  logic               cmp_we,
  input  logic [CNT_W-1:0]   cmp_wdata,
  input  logic               sts_clr,
  output logic [CFG_W-1:0]   cfg_rd,
  output logic [CNT_W-1:0]   cmp_rd,
  output logic [ROUTE_W-1:0] irq_route,
  output logic               irq_sts,
  output logic               irq_pulse,
  output logic               legacy_quiet
);
  chan_cfg_t cfg;

  logic [CNT_W-1:0] cmp_q, cmp_nxt, per_q, per_nxt;
  logic             cmp_ld;
  logic             armed_q, armed_nxt;
  logic             eval_q, eval_nxt;
  logic             en_d_q;
  logic             sts_q, sts_nxt;
  logic             pulse_q, pulse_nxt;
  logic             hit, behind_fire, fire;

  chan_cfg_reg #(.ROUTE_CAP(ROUTE_CAP)) u_cfg (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .wdata(cfg_wdata),
    .cfg(cfg), .rd_val(cfg_rd)
  );

  chan_match #(.CNT_W(CNT_W), .NARROW_W(NARROW_W), .PAST_WIN(PAST_WIN)) u_match (
    .cnt(main_cnt), .cmp(cmp_q), .narrow(cfg.narrow),
    .hit(hit), .behind_fire(behind_fire)
  );

  // fire decision: equality while armed, or a past target at the arming check
  always_comb begin
    fire = glb_en && cfg.int_en && (armed_q || eval_q) &&
           (hit || (eval_q && behind_fire));
  end

  always_comb begin
    cmp_ld  = cmp_we || (fire && cfg.periodic);
    cmp_nxt = cmp_we ? cmp_wdata : (cmp_q + per_q);
    per_nxt = cmp_wdata;

    eval_nxt = cmp_we || cfg_we || (glb_en && !en_d_q);

    if (!glb_en)                    armed_nxt = 1'b0;
    else if (fire && !cfg.periodic) armed_nxt = 1'b0;
    else if (eval_q)                armed_nxt = 1'b1;
    else                            armed_nxt = armed_q;

    sts_nxt   = (fire && cfg.level) || (sts_q && !sts_clr);
    pulse_nxt = fire && !cfg.level;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmp_q <= '0;
      per_q <= '0;
    end else begin
      if (cmp_ld) cmp_q <= cmp_nxt;
      if (cmp_we) per_q <= per_nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      eval_q  <= 1'b0;
      en_d_q  <= 1'b0;
      sts_q   <= 1'b0;
      pulse_q <= 1'b0;
    end else begin
      armed_q <= armed_nxt;
      eval_q  <= eval_nxt;
      en_d_q  <= glb_en;
      sts_q   <= sts_nxt;
      pulse_q <= pulse_nxt;
    end
  end

  generate
    if (CHAN_ID == 0) begin : g_legacy
      assign legacy_quiet = glb_legacy;
    end else begin : g_no_legacy
      logic unused_legacy;
      assign unused_legacy = glb_legacy;
      assign legacy_quiet  = 1'b0;
    end
  endgenerate

  assign cmp_rd    = cmp_q;
  assign irq_route = cfg.route;
  assign irq_sts   = sts_q;
  assign irq_pulse = pulse_q;
endmodule

// File: rtl/chan_timer_chk.sv
module chan_timer_chk #(
  parameter int CNT_W = 64
) (
  input logic             clk,
  input logic             rst_n,
  input logic             glb_en,
  input logic             cfg_level,
  input logic             cfg_inten,
  input logic             cmp_we,
  input logic [CNT_W-1:0] cmp_wdata,
  input logic [CNT_W-1:0] cmp_rd,
  input logic             sts_clr,
  input logic             irq_sts,
  input logic             irq_pulse
);
  // R10: pulses only come from edge-type configuration
  a_r10_edge_only: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pulse |-> !$past(cfg_level));

  // R11 and R13: a pulse needs global enable and interrupt enable one cycle earlier
  a_r11_gated_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pulse |-> ($past(glb_en) && $past(cfg_inten)));

  // R9: status is sticky without a clear
  a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_sts && !sts_clr) |=> irq_sts);

  // R9: a clear with no possible fire drops the status
  a_r9_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_clr && !glb_en) |=> !irq_sts);

  // R8: a comparator write always lands
  a_r8_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_we |=> (cmp_rd == $past(cmp_wdata)));
endmodule

bind chan_timer chan_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .glb_en(glb_en),
  .cfg_level(cfg_rd[1]), .cfg_inten(cfg_rd[2]),
  .cmp_we(cmp_we), .cmp_wdata(cmp_wdata), .cmp_rd(cmp_rd),
  .sts_clr(sts_clr), .irq_sts(irq_sts), .irq_pulse(irq_pulse)
);

// File: tb/sim_chan_timer.sv
module sim_chan_timer;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 10;

  typedef struct packed {
    logic        narrow;
    logic        inten;
    logic [63:0] cmp;
    logic [63:0] cnt;
    logic        fire;
  } vec_t;

  localparam vec_t VECS [NV] = '{
    '{1'b0, 1'b1, 64'd999,               64'd1000,              1'b1},
    '{1'b0, 1'b1, 64'd1005,              64'd1000,              1'b0},
    '{1'b0, 1'b1, 64'd1000,              64'd1000,              1'b1},
    '{1'b1, 1'b1, 64'd85682,             64'd100000,            1'b1},
    '{1'b1, 1'b1, 64'd85681,             64'd100000,            1'b0},
    '{1'b1, 1'b1, 64'h20,                64'h1_0000_0010,       1'b0},
    '{1'b0, 1'b1, 64'h20,                64'h1_0000_0010,       1'b1},
    '{1'b1, 1'b1, 64'd100000 + 64'h8000_0000, 64'd100000,       1'b0},
    '{1'b0, 1'b0, 64'd999,               64'd1000,              1'b0},
    '{1'b1, 1'b1, 64'hFFFF_FFF0,         64'h5,                 1'b1}
  };

  logic        clk, rst_n;
  logic [63:0] main_cnt, cfg_wdata, cmp_wdata;
  logic        glb_en, glb_legacy, cfg_we, cmp_we, sts_clr;
  logic [63:0] cfg_rd, cmp_rd, u1_cfg_rd, u1_cmp_rd;
  logic [4:0]  irq_route, u1_route;
  logic        irq_sts, irq_pulse, legacy_quiet;
  logic        u1_sts, u1_pulse, u1_legacy;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  chan_timer u0 (
    .clk(clk), .rst_n(rst_n), .main_cnt(main_cnt), .glb_en(glb_en),
    .glb_legacy(glb_legacy), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .cmp_we(cmp_we), .cmp_wdata(cmp_wdata), .sts_clr(sts_clr),
    .cfg_rd(cfg_rd), .cmp_rd(cmp_rd), .irq_route(irq_route),
    .irq_sts(irq_sts), .irq_pulse(irq_pulse), .legacy_quiet(legacy_quiet)
  );

  chan_timer #(.CHAN_ID(1)) u1 (
    .clk(clk), .rst_n(rst_n), .main_cnt(main_cnt), .glb_en(glb_en),
    .glb_legacy(glb_legacy), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .cmp_we(cmp_we), .cmp_wdata(cmp_wdata), .sts_clr(sts_clr),
    .cfg_rd(u1_cfg_rd), .cmp_rd(u1_cmp_rd), .irq_route(u1_route),
    .irq_sts(u1_sts), .irq_pulse(u1_pulse), .legacy_quiet(u1_legacy)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic do_reset;
    @(negedge clk);
    rst_n = 1'b0; glb_en = 1'b0; glb_legacy = 1'b0; cfg_we = 1'b0; cmp_we = 1'b0;
    sts_clr = 1'b0; cfg_wdata = '0; cmp_wdata = '0; main_cnt = '0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic wr_cfg(input logic [63:0] v);
    @(negedge clk); cfg_we = 1'b1; cfg_wdata = v;
    @(negedge clk); cfg_we = 1'b0;
  endtask

  task automatic wr_cmp(input logic [63:0] v);
    @(negedge clk); cmp_we = 1'b1; cmp_wdata = v;
    @(negedge clk); cmp_we = 1'b0;
  endtask

  task automatic count_up(input int from, input int upto);
    for (int v = from; v <= upto; v++) begin
      @(negedge clk); main_cnt = 64'(v);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int np;
    string tag;
    do_reset;
    @(negedge clk);
    // R1: reset state
    chk("R1 cfg", cfg_rd, 64'h00F0_0000_0000_0030);
    chk("R1 cmp", cmp_rd, 64'd0);
    chk("R1 sts", {63'd0, irq_sts}, 64'd0);
    chk("R1 pulse", {63'd0, irq_pulse}, 64'd0);
    chk("R1 route", {59'd0, irq_route}, 64'd0);

    // R2: writable mask and read-only capability bits
    wr_cfg('1);
    chk("R2 cfg", cfg_rd, 64'h00F0_0000_0000_3F3E);
    chk("R2 route", {59'd0, irq_route}, 64'h1F);

    // R4/R5/R6/R13: table of past/future comparator cases
    for (int i = 0; i < NV; i++) begin
      do_reset;
      main_cnt = VECS[i].cnt;
      wr_cfg((VECS[i].inten ? 64'h4 : 64'h0) | (VECS[i].narrow ? 64'h100 : 64'h0));
      wr_cmp(VECS[i].cmp);
      @(negedge clk); glb_en = 1'b1;
      if (!VECS[i].inten) tag = "R13";
      else if (i == 5 || i == 6) tag = "R4";
      else if (VECS[i].narrow) tag = "R6";
      else tag = "R5";
      @(negedge clk);
      chk({tag, " before eval"}, {63'd0, irq_pulse}, 64'd0);
      @(negedge clk);
      chk({tag, " at eval"}, {63'd0, irq_pulse}, {63'd0, VECS[i].fire});
    end

    // R3/R9/R7: running counter, level one-shot
    do_reset;
    main_cnt = 64'd150;
    wr_cfg(64'h6);
    wr_cmp(64'd200);
    @(negedge clk); glb_en = 1'b1;
    for (int v = 151; v <= 200; v++) begin
      @(negedge clk);
      chk("R3 before match", {63'd0, irq_sts}, 64'd0);
      main_cnt = 64'(v);
    end
    @(negedge clk);
    chk("R3 match", {63'd0, irq_sts}, 64'd1);
    repeat (4) @(negedge clk);
    chk("R9 sticky", {63'd0, irq_sts}, 64'd1);
    sts_clr = 1'b1;
    @(negedge clk); sts_clr = 1'b0;
    chk("R9 clear", {63'd0, irq_sts}, 64'd0);
    repeat (3) @(negedge clk);
    chk("R7 one-shot no refire", {63'd0, irq_sts}, 64'd0);

    // R7/R10: periodic edge, period 10
    do_reset;
    wr_cfg(64'hC);
    wr_cmp(64'd10);
    @(negedge clk); glb_en = 1'b1;
    np = 0;
    for (int v = 1; v <= 35; v++) begin
      @(negedge clk);
      if (irq_pulse) np++;
      main_cnt = 64'(v);
    end
    @(negedge clk);
    if (irq_pulse) np++;
    chk("R7 periodic pulses", 64'(np), 64'd3);
    chk("R7 comparator advanced", cmp_rd, 64'd40);
    chk("R10 edge leaves status", {63'd0, irq_sts}, 64'd0);

    // R9: fire and clear in the same cycle
    do_reset;
    wr_cfg(64'hE);
    wr_cmp(64'd10);
    @(negedge clk); glb_en = 1'b1;
    count_up(1, 9);
    @(negedge clk); main_cnt = 64'd10; sts_clr = 1'b1;
    @(negedge clk); main_cnt = 64'd11;
    chk("R9 set beats clear", {63'd0, irq_sts}, 64'd1);
    @(negedge clk); sts_clr = 1'b0;
    chk("R9 clear next", {63'd0, irq_sts}, 64'd0);

    // R8: comparator write against periodic reload
    do_reset;
    wr_cfg(64'hC);
    wr_cmp(64'd10);
    @(negedge clk); glb_en = 1'b1;
    count_up(1, 9);
    @(negedge clk); main_cnt = 64'd10; cmp_we = 1'b1; cmp_wdata = 64'd50;
    @(negedge clk); cmp_we = 1'b0; main_cnt = 64'd11;
    chk("R8 pulse", {63'd0, irq_pulse}, 64'd1);
    chk("R8 write wins", cmp_rd, 64'd50);

    // R11: cancel while disabled, re-evaluate on enable
    do_reset;
    wr_cfg(64'h4);
    wr_cmp(64'd5);
    @(negedge clk); glb_en = 1'b1;
    repeat (2) @(negedge clk);
    glb_en = 1'b0;
    np = 0;
    for (int v = 1; v <= 8; v++) begin
      @(negedge clk);
      if (irq_pulse) np++;
      main_cnt = 64'(v);
    end
    @(negedge clk);
    if (irq_pulse) np++;
    chk("R11 no fire disabled", 64'(np), 64'd0);
    glb_en = 1'b1;
    @(negedge clk);
    chk("R11 before re-eval", {63'd0, irq_pulse}, 64'd0);
    @(negedge clk);
    chk("R11 re-eval fires", {63'd0, irq_pulse}, 64'd1);

    // R12: legacy quiet only on channel 0
    @(negedge clk); glb_legacy = 1'b1;
    @(negedge clk);
    chk("R12 ch0 quiet", {63'd0, legacy_quiet}, 64'd1);
    chk("R12 ch1 silent", {63'd0, u1_legacy}, 64'd0);
    glb_legacy = 1'b0;
    @(negedge clk);
    chk("R12 ch0 released", {63'd0, legacy_quiet}, 64'd0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule